// File: doc/BRIEF.md
# I2C Transaction Time-out Timer

This block bounds how long a single I2C transaction may run. A configuration byte holds an enable flag in its least significant bit and, in its upper seven bits, the high part of the reload value. When the I2C engine signals the start of a transaction, a 16-bit down counter is reloaded. Its nine low bits are filled with ones, and its upper seven bits come from the configuration byte.

While the transaction is in progress and the timer is enabled, an internal prescaler divides the system clock into a time-base tick, and the counter steps down by one on each tick. A done pulse from the engine freezes the counter and closes the transaction. If the counter instead reaches zero while the transaction is still open, the block emits a single-cycle time-out pulse, closes the transaction and loads the time-out status code.

The I2C engine and the clock source are outside this block. They appear only as the start and done inputs and the system clock.

Top module: `i2c_txn_timeout`

## Requirements
- R1: After reset, status_o is 8'hF0, busy_o is 0, timeout_o is 0 and count_o is 0. The configuration byte resets to 8'h00, which means disabled.
- R2: While busy_o is 1 and configuration bit 0 is 1, count_o decreases by exactly one every PRESCALE clock cycles. The prescaler restarts at each start pulse, so the first decrement lands PRESCALE cycles after the start is registered. count_o never goes below zero.
- R3: A start pulse loads count_o with {cfg[7:1], 9'h1FF}, sets busy_o and sets status_o to 8'hF3. It does this whether or not the timer is enabled, and a start during an open transaction reloads the counter again.
- R4: A done pulse while busy_o is 1 clears busy_o, sets status_o to 8'hF0 and freezes count_o at its current value, and no time-out follows. A done pulse while busy_o is 0 changes nothing.
- R5: When count_o is zero, busy_o is 1 and the timer is enabled, timeout_o is high for exactly one cycle on the next clock. On that same clock status_o becomes 8'hF8 and busy_o clears. Measured from the clock that registers the start, the pulse appears N*PRESCALE+1 clocks later, where N is the reload value.
- R6: When configuration bit 0 is 0, the counter does not decrement and no time-out is raised, but busy_o stays set until done.
- R7: While busy_o is 0, count_o holds its value.
- R8: When start and done are high in the same cycle, start wins.
- R9: A configuration write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_data_i | input | 8 | Configuration byte: bit 0 enable, bits 7:1 reload upper bits |
| xfer_start_i | input | 1 | Transaction start pulse |
| xfer_done_i | input | 1 | Transaction done pulse |
| timeout_o | output | 1 | One-cycle time-out event |
| busy_o | output | 1 | Transaction open |
| status_o | output | 8 | Transaction status code |
| count_o | output | 16 | Current down-counter value |

## Verification
The bench builds the block with PRESCALE set to 2. With that setting, a full expiry for reload upper bits of 0 (N = 511) or 1 (N = 1023) takes about a thousand or two thousand clocks. This puts the exact time-out latency, the one-cycle pulse and the F8 status within reach of a short run. The divide-by-two tick also makes the per-tick step visible within a handful of cycles. Larger reload values and the default division are not exercised, since the counter logic is the same across all reload values.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int CNT_W  = 16;
  localparam int FILL_W = 9;
  localparam int CFG_W  = 8;

  typedef enum logic [7:0] {
    ST_OK      = 8'hF0,
    ST_BUSY    = 8'hF3,
    ST_TIMEOUT = 8'hF8
  } tmo_status_e;

  function automatic logic [CNT_W-1:0] reload_of(input logic [CFG_W-1:0] cfg);
    return {cfg[CFG_W-1:1], {FILL_W{1'b1}}};
  endfunction
endpackage

// File: rtl/tmo_rst_sync.sv
module tmo_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          wrap;

  assign wrap = (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (run_i) pre_d = wrap ? '0 : pre_q + 1'b1;
  end

  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pre_q <= '0;
    else          pre_q <= pre_d;
  end
endmodule

// File: rtl/tmo_downcounter.sv
module tmo_downcounter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)               cnt_d = load_val_i;
    else if (dec_i && !zero_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmo_ctrl.sv
module tmo_ctrl
  import tmo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       en_i,
  input  logic       zero_i,
  output logic       busy_o,
  output logic       timeout_o,
  output logic [7:0] status_o
);
  logic        busy_q, busy_d;
  logic        tmo_q, tmo_d;
  tmo_status_e st_q, st_d;
  logic        expire;

  assign expire = busy_q && en_i && zero_i && !done_i && !start_i;

  always_comb begin
    busy_d = busy_q;
    st_d   = st_q;
    tmo_d  = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      st_d   = ST_BUSY;
    end else if (busy_q && done_i) begin
      busy_d = 1'b0;
      st_d   = ST_OK;
    end else if (expire) begin
      busy_d = 1'b0;
      st_d   = ST_TIMEOUT;
      tmo_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      tmo_q  <= 1'b0;
      st_q   <= ST_OK;
    end else begin
      busy_q <= busy_d;
      tmo_q  <= tmo_d;
      st_q   <= st_d;
    end
  end

  assign busy_o    = busy_q;
  assign timeout_o = tmo_q;
  assign status_o  = st_q;
endmodule

// File: rtl/i2c_txn_timeout.sv
module i2c_txn_timeout
  import tmo_pkg::*;
#(
  parameter int unsigned PRESCALE = 2170
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic              timeout_o,
  output logic              busy_o,
  output logic [7:0]        status_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             tick;
  logic             cnt_zero;
  logic             run;

  tmo_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_i) cfg_d = cfg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  assign run = busy_o && cfg_q[0];

  tmo_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .clr_i   (xfer_start_i),
    .run_i   (run),
    .tick_o  (tick)
  );

  tmo_downcounter #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .load_i     (xfer_start_i),
    .load_val_i (reload_of(cfg_q)),
    .dec_i      (tick && !xfer_done_i),
    .count_o    (count_o),
    .zero_o     (cnt_zero)
  );

  tmo_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .start_i   (xfer_start_i),
    .done_i    (xfer_done_i),
    .en_i      (cfg_q[0]),
    .zero_i    (cnt_zero),
    .busy_o    (busy_o),
    .timeout_o (timeout_o),
    .status_o  (status_o)
  );
endmodule

// File: rtl/tmo_checker.sv
module tmo_checker (
  input logic        clk_i,
  input logic        rst_n,
  input logic        start_i,
  input logic        done_i,
  input logic [7:0]  cfg_q,
  input logic        busy_o,
  input logic        timeout_o,
  input logic [7:0]  status_o,
  input logic [15:0] count_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r5_status_code: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> (status_o == 8'hF8 && !busy_o));

  a_r6_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
    timeout_o |-> ($past(cfg_q[0]) && $past(busy_o)));

  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (count_o == {$past(cfg_q[7:1]), 9'h1FF} && busy_o && status_o == 8'hF3));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    !start_i |=> (count_o == $past(count_o) || count_o == $past(count_o) - 16'd1));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(count_o));

  a_r6_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_q[0] && !start_i) |=> $stable(count_o));

  a_r4_done_closes: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && done_i && !start_i) |=> (!busy_o && !timeout_o && status_o == 8'hF0));
endmodule

bind i2c_txn_timeout tmo_checker u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .start_i   (xfer_start_i),
  .done_i    (xfer_done_i),
  .cfg_q     (cfg_q),
  .busy_o    (busy_o),
  .timeout_o (timeout_o),
  .status_o  (status_o),
  .count_o   (count_o)
);

// File: tb/i2c_txn_timeout_tb.sv
module i2c_txn_timeout_tb;
  localparam int P = 2;

  logic        clk_i = 1'b0;
  logic        rst_n_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_data_i = 8'h00;
  logic        xfer_start_i = 1'b0;
  logic        xfer_done_i = 1'b0;
  logic        timeout_o;
  logic        busy_o;
  logic [7:0]  status_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int since = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  i2c_txn_timeout #(.PRESCALE(P)) u_dut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .xfer_start_i(xfer_start_i), .xfer_done_i(xfer_done_i), .timeout_o(timeout_o),
    .busy_o(busy_o), .status_o(status_o), .count_o(count_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr_i = 1'b1; cfg_data_i = v;
    step(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic pulse_start();
    xfer_start_i = 1'b1;
    step(1);
    xfer_start_i = 1'b0;
  endtask

  task automatic pulse_done();
    xfer_done_i = 1'b1;
    step(1);
    xfer_done_i = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy_o; i++) step(1);
  endtask

  // monitor: measures start-to-timeout latency and compares with the scoreboard
  always @(negedge clk_i) begin
    if (xfer_start_i) since = 0;
    else since++;
    if (timeout_o) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected timeout", since, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(since == e, "R5 timeout latency", since, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    step(3);
    rst_n_i = 1'b1;
    step(4);
    // R1 reset state
    check(status_o == 8'hF0, "R1 status", status_o, 8'hF0);
    check(!busy_o && !timeout_o, "R1 busy/timeout", {busy_o, timeout_o}, 0);
    check(count_o == 16'h0, "R1 count", count_o, 0);

    // R6 disabled: load happens, no decrement, no timeout
    write_cfg(8'h00);
    pulse_start();
    check(count_o == 16'd511, "R3 load disabled", count_o, 511);
    check(status_o == 8'hF3 && busy_o, "R3 busy status", status_o, 8'hF3);
    step(1500);
    check(count_o == 16'd511, "R6 no decrement", count_o, 511);
    check(busy_o == 1'b1, "R6 busy kept", busy_o, 1);
    pulse_done();
    check(status_o == 8'hF0 && !busy_o, "R4 done after disabled", status_o, 8'hF0);

    // R9 config write, R2 step rate
    write_cfg(8'h01);
    pulse_start();
    check(count_o == 16'd511, "R9 new cfg used", count_o, 511);
    step(10);
    check(count_o == 16'd511 - 16'(10 / P), "R2 decrement rate", count_o, 511 - 10 / P);
    // R3 restart while busy
    pulse_start();
    check(count_o == 16'd511, "R3 restart reload", count_o, 511);
    // R4 done freezes
    step(100);
    pulse_done();
    begin
      logic [15:0] frozen;
      frozen = count_o;
      check(!busy_o && status_o == 8'hF0, "R4 done closes", status_o, 8'hF0);
      step(1200);
      check(count_o == frozen, "R7 hold when idle", count_o, frozen);
    end
    // R4 done while idle ignored
    pulse_done();
    check(status_o == 8'hF0 && !busy_o, "R4 idle done ignored", status_o, 8'hF0);

    // R5 expiry, N=511
    exp_q.push_back(511 * P + 2);
    pulse_start();
    wait_idle(3000);
    step(2);
    check(status_o == 8'hF8, "R5 status F8", status_o, 8'hF8);
    check(count_o == 16'h0 && !busy_o, "R5 count zero", count_o, 0);
    pulse_done();
    check(status_o == 8'hF8, "R4 done after timeout ignored", status_o, 8'hF8);

    // R5 expiry, N=1023 via cfg bit 1
    write_cfg(8'h03);
    exp_q.push_back(1023 * P + 2);
    pulse_start();
    check(count_o == 16'd1023, "R3 upper bits", count_o, 1023);
    wait_idle(5000);
    step(2);
    check(status_o == 8'hF8, "R5 status F8 long", status_o, 8'hF8);

    // R8 start and done together
    xfer_start_i = 1'b1; xfer_done_i = 1'b1;
    step(1);
    xfer_start_i = 1'b0; xfer_done_i = 1'b0;
    check(busy_o && status_o == 8'hF3, "R8 start wins", status_o, 8'hF3);
    check(count_o == 16'd1023, "R8 reload", count_o, 1023);
    pulse_done();
    step(4);
    check(exp_q.size() == 0, "R5 all timeouts seen", exp_q.size(), 0);
    finish_run();
  end
endmodule